// File: doc/BRIEF.md
# Bus Release Request Handshake Unit

This unit handles the handshake in which an external device asks for a data bus cycle and the DMA side answers with a bus-available strobe. The request line is synchronous and sampled on the rising clock edge. Only a low-to-high change counts, so a line held high asks once. A request sampled at one edge is accepted at the next edge, and the strobe starts at the edge after that.

The strobe normally lasts one clock. The row-miss input is sampled at the edge where the strobe starts. If it is high there, that edge marks a row-address miss to a bank that was not precharged, and the strobe is held for a programmable precharge interval instead. A request that rises while such a held strobe is showing is dropped without any trace.

The requester must not raise the line again until it has seen the strobe for its previous request. A rise that comes while a request is still waiting for its strobe is discarded and sets a sticky violation flag. The flag clears only on reset.

Top module: `busrel_hs`

## Requirements
- R1: While reset is asserted, and right after it is asserted, `bavl_o` and `viol_o` are both 0, whatever the other inputs are.
- R2: If `req_i` is sampled high at edge E and was sampled low at edge E-1, the request is accepted at E+1 and `bavl_o` goes high after edge E+2.
- R3: If `row_miss_i` is 0 at the edge where the strobe starts, `bavl_o` stays high for exactly one cycle.
- R4: If `row_miss_i` is 1 at the edge where the strobe starts, `bavl_o` stays high for `tcp_i`+1 cycles. `tcp_i` is an unsigned count taken at that same edge, so 0 gives 1 cycle and 7 gives 8 cycles.
- R5: A `req_i` held high over many edges produces only one strobe.
- R6: A rise of `req_i` sampled at an edge where a held (row-miss) strobe is showing produces no strobe and does not set `viol_o`.
- R7: A rise of `req_i` sampled while an earlier request is accepted but its strobe has not yet started sets `viol_o`. It produces no strobe, and later legal requests are still served.
- R8: Once set, `viol_o` stays 1 until reset.
- R9: A rise of `req_i` sampled at the edge that ends a one-cycle strobe is legal. It is served normally and does not set `viol_o`.
- R10: `row_miss_i` and `tcp_i` have no effect except at the edge where a strobe starts. Changing them in the middle of a held strobe does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | External bus request, synchronous, counted on its rising change |
| row_miss_i | input | 1 | Row-address miss to a non-precharged bank, taken at strobe start |
| tcp_i | input | TCP_W | Precharge interval; a held strobe lasts this value plus one cycles |
| bavl_o | output | 1 | Bus-available strobe |
| viol_o | output | 1 | Sticky flag for a request raised before its predecessor's strobe |

## Verification
Two pairs of functions can land on the same edge. The first pair is a strobe starting while a new request rise is sampled. The bench raises the request again exactly two cycles after a first rise, so the violating rise meets the launch edge of the first strobe. The expected result is a strobe together with a raised flag, and no second strobe later. The second pair is a held strobe and an incoming rise. The bench drives the rise on the last cycle of an eight-cycle hold and expects that request to vanish with no flag. As a contrast, a rise on the single cycle of a normal strobe must be served.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

  // Default width of the precharge interval setting.
  localparam int unsigned BUSREL_TCP_W = 3;

  // Number of flops in the reset release chain.
  localparam int unsigned BUSREL_RST_STAGES = 2;

  // Strobe generator states.
  typedef enum logic [1:0] {
    STB_IDLE  = 2'd0,
    STB_PULSE = 2'd1,
    STB_HOLD  = 2'd2
  } stb_state_e;

endpackage

// File: rtl/busrel_rst_sync.sv
module busrel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in after release; asserting is asynchronous.
  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/busrel_req_edge.sv
module busrel_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);

  logic req_q;

  // Previous sampled level of the request line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_i;
    end
  end

  // A fresh request: high now, low at the previous edge.
  assign rise_o = req_i & ~req_q;

endmodule

// File: rtl/busrel_accept.sv
module busrel_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic hold_i,
  output logic launch_o,
  output logic violate_o
);

  logic take_q, take_d;
  logic acc_q, acc_d;
  logic owed;
  logic live_rise;

  // A request is owed a strobe from its sampling until the strobe starts.
  assign owed      = take_q | acc_q;
  // Rises during a held strobe are dropped before anything else.
  assign live_rise = rise_i & ~hold_i;

  always_comb begin
    take_d    = live_rise & ~owed;
    acc_d     = take_q;
    violate_o = live_rise & owed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      take_q <= take_d;
      acc_q  <= acc_d;
    end
  end

  assign launch_o = acc_q;

endmodule

// File: rtl/busrel_strobe.sv
module busrel_strobe
  import busrel_pkg::*;
#(
  parameter int unsigned TCP_W = BUSREL_TCP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             miss_i,
  input  logic [TCP_W-1:0] tcp_i,
  output logic             bavl_o,
  output logic             hold_o
);

  localparam logic [TCP_W-1:0] CNT_ONE = TCP_W'(1);

  stb_state_e       st_q, st_d;
  logic [TCP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (launch_i) begin
      // Miss and interval are only looked at here.
      st_d  = miss_i ? STB_HOLD : STB_PULSE;
      cnt_d = miss_i ? tcp_i : '0;
    end else begin
      case (st_q)
        STB_PULSE: st_d = STB_IDLE;
        STB_HOLD: begin
          if (cnt_q == '0) begin
            st_d = STB_IDLE;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  assign cnt_en = launch_i | (st_q == STB_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= STB_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign bavl_o = (st_q != STB_IDLE);
  assign hold_o = (st_q == STB_HOLD);

endmodule

// File: rtl/busrel_viol.sv
module busrel_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (event_i) begin
      flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/busrel_hs.sv
module busrel_hs
  import busrel_pkg::*;
#(
  parameter int unsigned TCP_W      = BUSREL_TCP_W,
  parameter int unsigned RST_STAGES = BUSREL_RST_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             row_miss_i,
  input  logic [TCP_W-1:0] tcp_i,
  output logic             bavl_o,
  output logic             viol_o
);

  logic rst_n_s;
  logic rise;
  logic launch;
  logic violate;
  logic hold;

  busrel_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  busrel_req_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .req_i  (req_i),
    .rise_o (rise)
  );

  busrel_accept u_acc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rise_i    (rise),
    .hold_i    (hold),
    .launch_o  (launch),
    .violate_o (violate)
  );

  busrel_strobe #(.TCP_W(TCP_W)) u_stb (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .launch_i (launch),
    .miss_i   (row_miss_i),
    .tcp_i    (tcp_i),
    .bavl_o   (bavl_o),
    .hold_o   (hold)
  );

  busrel_viol u_viol (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .event_i (violate),
    .flag_o  (viol_o)
  );

endmodule

// File: rtl/busrel_hs_chk.sv
module busrel_hs_chk #(
  parameter int unsigned TCP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             row_miss_i,
  input logic [TCP_W-1:0] tcp_i,
  input logic             bavl_o,
  input logic             viol_o
);

  logic             miss_q;
  logic [TCP_W-1:0] tcp_q;
  logic             bav_q;
  logic [TCP_W:0]   run_q;
  logic [TCP_W:0]   exp_q;

  // Track the length of each strobe and the length it should have.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= 1'b0;
      tcp_q  <= '0;
      bav_q  <= 1'b0;
      run_q  <= '0;
      exp_q  <= '0;
    end else begin
      miss_q <= row_miss_i;
      tcp_q  <= tcp_i;
      bav_q  <= bavl_o;
      if (bavl_o && !bav_q) begin
        run_q <= (TCP_W+1)'(1);
        exp_q <= miss_q ? ({1'b0, tcp_q} + (TCP_W+1)'(1)) : (TCP_W+1)'(1);
      end else if (bavl_o) begin
        run_q <= run_q + (TCP_W+1)'(1);
      end
    end
  end

  AST_STROBE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bavl_o) |-> $past(req_i, 3)); // R2

  AST_PLAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bavl_o) && !$past(row_miss_i)) |=> !bavl_o); // R3

  AST_STROBE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bavl_o && bav_q) |-> (run_q == exp_q)); // R4

  AST_VIOL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_o) |-> $past(req_i)); // R7

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> viol_o); // R8

endmodule

bind busrel_hs busrel_hs_chk #(.TCP_W(TCP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .row_miss_i (row_miss_i),
  .tcp_i      (tcp_i),
  .bavl_o     (bavl_o),
  .viol_o     (viol_o)
);

// File: tb/sim_busrel_hs.sv
`timescale 1ns/1ps
module sim_busrel_hs;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic       miss;
  logic [2:0] tcp;
  logic       bavl;
  logic       viol;

  int nvec;
  int nbad;
  bit done;

  busrel_hs #(.TCP_W(3)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .row_miss_i (miss),
    .tcp_i      (tcp),
    .bavl_o     (bavl),
    .viol_o     (viol)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Fields: [6] req, [5] miss, [4:2] tcp, [1] expected bavl, [0] expected viol.
  // Each row is applied for one edge and checked just after that edge.
  localparam int NV = 27;
  localparam logic [6:0] VEC [NV] = '{
    7'b0000000, //  0 idle
    7'b1000000, //  1 R2 rise sampled
    7'b1000000, //  2 R5 held high, accepted
    7'b0000010, //  3 R2 R3 strobe starts
    7'b0000000, //  4 R3 one cycle only
    7'b0000000, //  5 R5 no second strobe
    7'b1000000, //  6 R9 rise
    7'b0000000, //  7
    7'b0000010, //  8 R9 strobe
    7'b1000000, //  9 R9 reassert seen on strobe
    7'b0000000, // 10
    7'b0000010, // 11 R9 served, no flag
    7'b1000000, // 12 R4 rise
    7'b0000000, // 13
    7'b0101010, // 14 R4 start with miss, interval 2
    7'b0000010, // 15 R10 miss and interval change mid hold
    7'b1000010, // 16 R6 rise inside hold, last cycle
    7'b0000000, // 17 R4 ended after 3 cycles
    7'b0000000, // 18 R6 ignored, no strobe
    7'b0000000, // 19 R6
    7'b0000000, // 20 R6 no flag
    7'b1000000, // 21 R7 rise
    7'b0000000, // 22 R7 accepted
    7'b1000011, // 23 R7 early rise on launch edge
    7'b0000001, // 24 R7
    7'b0000001, // 25 R7 discarded, no strobe
    7'b0000001  // 26 R8 flag held
  };

  task automatic apply(input logic r, input logic m, input logic [2:0] t);
    @(negedge clk);
    req  = r;
    miss = m;
    tcp  = t;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic eb, input logic ev, input string tag);
    nvec++;
    if (bavl !== eb || viol !== ev) begin
      nbad++;
      $display("FAIL %s: bavl=%0b viol=%0b, expected bavl=%0b viol=%0b",
               tag, bavl, viol, eb, ev);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) apply(1'b0, 1'b0, 3'd0);
  endtask

  initial begin
    nvec = 0;
    nbad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    req = 1'b1;
    miss = 1'b1;
    tcp = 3'd5;
    repeat (3) @(posedge clk);
    #1;
    chk(1'b0, 1'b0, "R1 during reset");
    @(negedge clk);
    req = 1'b0;
    miss = 1'b0;
    tcp = 3'd0;
    rst_n = 1'b1;
    idle(4);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][6], VEC[i][5], VEC[i][4:2]);
      chk(VEC[i][1], VEC[i][0], $sformatf("vector %0d", i));
    end

    // R1 R8: reset clears the sticky flag at once.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(1'b0, 1'b0, "R1 R8 reset clears flag");
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R4: longest hold, 8 cycles; R6: rise on its final cycle is dropped.
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b0, "R4 rise");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b0, "R4 accept");
    apply(1'b0, 1'b1, 3'd7); chk(1'b1, 1'b0, "R4 hold cycle 1");
    for (int k = 2; k <= 7; k++) begin
      apply(1'b0, 1'b0, 3'd0);
      chk(1'b1, 1'b0, $sformatf("R4 hold cycle %0d", k));
    end
    apply(1'b1, 1'b0, 3'd0); chk(1'b1, 1'b0, "R4 hold cycle 8, R6 rise");
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b0, "R4 hold over");
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b0, "R6 R5 no strobe");
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b0, "R6 R5 no strobe");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b0, "R6 no flag");

    // R4: interval 0 with a miss gives a single cycle.
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b0, "R4 zero rise");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b0, "R4 zero accept");
    apply(1'b0, 1'b1, 3'd0); chk(1'b1, 1'b0, "R4 zero strobe");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b0, "R4 zero over");
    idle(2);

    // R7: violation, then a legal request is still served; R8 flag stays.
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b0, "R7 rise");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b0, "R7 accept");
    apply(1'b1, 1'b0, 3'd0); chk(1'b1, 1'b1, "R7 early rise");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b1, "R7 after");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b1, "R7 dropped");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b1, "R8 held");
    apply(1'b1, 1'b0, 3'd0); chk(1'b0, 1'b1, "R7 legal rise");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b1, "R7 legal accept");
    apply(1'b0, 1'b0, 3'd0); chk(1'b1, 1'b1, "R7 legal served");
    apply(1'b0, 1'b0, 3'd0); chk(1'b0, 1'b1, "R3 R8 end");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule